// File: doc/BRIEF.md
# NAND Copy-Back Program Sequencer

This block runs an internal page copy on an asynchronous 8-bit NAND flash device from the host side. The data never leaves the flash. A single start pulse supplies a source page row and a target page row. The sequencer then loads the source page into the device's page buffer and waits out the read busy period. After that it opens the program phase with the target address. Before it confirms the program, it can splice in any number of column-addressed byte patches. It then waits out the program busy period, reads the status byte, and reports done with a pass or fail flag.

The host supplies patches on a small valid/ready port. A patch marked "first" opens a new random-data run: the block sends the program code, then two column cycles, then the byte. An unmarked patch appends one more byte to the current run. The patch marked "last" closes the list. Strobe widths and the busy timeout are cycle counts set by parameters. A busy period that does not finish within the timeout aborts the operation with an error.

States: IDLE, RD_CMD, RD_ADDR, RD_CONF, RD_BUSY, PG_CMD, PG_ADDR, PT_WAIT, PT_CMD, PT_COL, PT_DATA, PG_CONF, PG_BUSY, ST_CMD, ST_READ, FINISH. Transitions:
- IDLE→RD_CMD on start.
- RD_CMD→RD_ADDR, RD_ADDR→RD_CONF after the fourth address cycle, RD_CONF→RD_BUSY.
- RD_BUSY→PG_CMD when busy clears, or RD_BUSY→FINISH on timeout.
- PG_CMD→PG_ADDR.
- PG_ADDR→PT_WAIT when patches were requested, otherwise PG_ADDR→PG_CONF.
- PT_WAIT→PT_CMD for a first patch, or PT_WAIT→PT_DATA for a continuation.
- PT_CMD→PT_COL, PT_COL→PT_DATA after two cycles.
- PT_DATA→PG_CONF on the last patch, otherwise PT_DATA→PT_WAIT.
- PG_CONF→PG_BUSY.
- PG_BUSY→ST_CMD when busy clears, or PG_BUSY→FINISH on timeout.
- ST_CMD→ST_READ, ST_READ→FINISH, FINISH→IDLE.

Top module: `nand_cb_seq`

## Requirements
- R1: The read phase issues command 00h, then four address cycles, then command 35h. The address cycles go column low, column high, row low, row high. The column is 0 and the row is src_row, with unused high bits driven to 0.
- R2: After 35h the block waits for nand_rb to go low and then high again before it issues anything else. No cycle is latched while nand_rb is low.
- R3: The program phase issues command 85h, then four address cycles with column 0 and row dst_row, in the same order as R1.
- R4: A patch accepted with pt_first=1 emits 85h, then column low, then column high (pt_col zero-extended to 16 bits), then a data cycle carrying pt_data. A patch with pt_first=0 emits only the data cycle. pt_ready is high only while the block waits for a patch, and any number of patches may follow.
- R5: With has_patch=0 at start, command 10h follows the fourth target address cycle directly.
- R6: After the last patch (or per R5), the block issues 10h and waits through the busy period as in R2. It then issues 70h and makes exactly one read cycle of T_RL clocks with nand_io_oe low. fail takes bit 0 of the byte read (1 = failed).
- R7: Each cycle is latched on the rising edge of nand_we_n, which stays low for exactly T_WL clocks. The latch lines are set by cycle type: commands use nand_cle=1, nand_ale=0; addresses use nand_ale=1, nand_cle=0; data uses both at 0. nand_cle, nand_ale and nand_io_out do not change at the rising edge.
- R8: If a busy wait does not complete within TIMEOUT clocks, the block ends with done, fail=1 and timeout=1. It issues no further cycles and returns nand_ce_n high.
- R9: busy is high from the clock after an accepted start through the done cycle. nand_ce_n is low exactly while busy is high. done is a one-clock pulse. fail and timeout hold their values until the next start.
- R10: start is ignored while busy is high. The bus sequence in progress and its addresses are unchanged.
- R11: After reset: nand_ce_n, nand_we_n, nand_re_n are 1; nand_cle, nand_ale, nand_io_oe, busy, done, pt_ready are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a copy-back operation when idle |
| src_row | input | ROW_W | Source page row |
| dst_row | input | ROW_W | Target page row |
| has_patch | input | 1 | A patch list follows the target address |
| pt_valid | input | 1 | Patch entry valid |
| pt_first | input | 1 | Entry opens a new column run |
| pt_last | input | 1 | Entry is the final patch |
| pt_col | input | COL_W | Column for a first entry |
| pt_data | input | 8 | Patch byte |
| pt_ready | output | 1 | Block waits for a patch entry |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| fail | output | 1 | Operation failed (status bit 0 or timeout) |
| timeout | output | 1 | A busy wait expired |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | I/O bus value driven |
| nand_io_oe | output | 1 | I/O bus drive enable |
| nand_io_in | input | 8 | I/O bus value read |
| nand_rb | input | 1 | Ready/busy from device, low while busy |

## Verification
The bench builds the block with T_WL=2, T_WH=1, T_RL=2 and TIMEOUT=200. With these values every strobe width can be counted cycle by cycle. The timeout abort is reached after a few hundred clocks instead of a realistic busy budget. The behavioural flash responder holds ready/busy low for 20 clocks, well inside the timeout. It can also hold the line low indefinitely, so that both the normal busy path and the expiry path can be checked in one short run.

// File: rtl/nand_cb_pkg.sv
package nand_cb_pkg;

    typedef enum logic [4:0] {
        S_IDLE, S_RD_CMD, S_RD_ADDR, S_RD_CONF, S_RD_BUSY,
        S_PG_CMD, S_PG_ADDR, S_PT_WAIT, S_PT_CMD, S_PT_COL, S_PT_DATA,
        S_PG_CONF, S_PG_BUSY, S_ST_CMD, S_ST_READ, S_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        CYC_CMD, CYC_ADDR, CYC_DATA, CYC_READ
    } cyc_kind_t;

    localparam logic [7:0] OP_PAGE_READ = 8'h00;
    localparam logic [7:0] OP_CB_READ   = 8'h35;
    localparam logic [7:0] OP_PROG      = 8'h85;
    localparam logic [7:0] OP_CONFIRM   = 8'h10;
    localparam logic [7:0] OP_STATUS    = 8'h70;

endpackage

// File: rtl/nand_cb_bus.sv
module nand_cb_bus
    import nand_cb_pkg::*;
#(
    parameter int T_WL = 2,
    parameter int T_WH = 1,
    parameter int T_RL = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go,
    input  cyc_kind_t kind,
    input  logic [7:0] wbyte,
    output logic      fin,
    output logic [7:0] rbyte,
    output logic      cle,
    output logic      ale,
    output logic      we_n,
    output logic      re_n,
    output logic [7:0] io_out,
    output logic      io_oe,
    input  logic [7:0] io_in
);
    localparam int T_MAX = (T_WL > T_RL) ? ((T_WL > T_WH) ? T_WL : T_WH)
                                         : ((T_RL > T_WH) ? T_RL : T_WH);
    localparam int CW = $clog2(T_MAX + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_t;

    phase_t        ph;
    logic [CW-1:0] cnt;
    cyc_kind_t     k_q;
    logic [7:0]    b_q;
    logic [7:0]    rd_q;
    logic [CW-1:0] low_last;

    assign low_last = (k_q == CYC_READ) ? CW'(T_RL - 1) : CW'(T_WL - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph   <= PH_IDLE;
            cnt  <= '0;
            k_q  <= CYC_CMD;
            b_q  <= '0;
            rd_q <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: if (go) begin
                    ph  <= PH_LOW;
                    cnt <= '0;
                    k_q <= kind;
                    b_q <= wbyte;
                end
                PH_LOW: if (cnt == low_last) begin
                    ph  <= PH_HIGH;
                    cnt <= '0;
                    if (k_q == CYC_READ) rd_q <= io_in;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                PH_HIGH: if (cnt == CW'(T_WH - 1)) begin
                    ph  <= PH_IDLE;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        fin    = (ph == PH_HIGH) && (cnt == CW'(T_WH - 1));
        cle    = (ph != PH_IDLE) && (k_q == CYC_CMD);
        ale    = (ph != PH_IDLE) && (k_q == CYC_ADDR);
        we_n   = !((ph == PH_LOW) && (k_q != CYC_READ));
        re_n   = !((ph == PH_LOW) && (k_q == CYC_READ));
        io_oe  = (ph != PH_IDLE) && (k_q != CYC_READ);
        io_out = io_oe ? b_q : 8'h00;
        rbyte  = rd_q;
    end

endmodule

// File: rtl/nand_cb_rbwait.sv
module nand_cb_rbwait #(
    parameter int TIMEOUT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic rb_async,
    output logic fin,
    output logic tmo
);
    localparam int TW = $clog2(TIMEOUT + 1);

    typedef enum logic [1:0] {W_IDLE, W_LOW, W_HIGH} wphase_t;

    wphase_t       ph;
    logic [TW-1:0] cnt;
    logic          rb_s1, rb_s2;
    logic          expired;

    assign expired = (ph != W_IDLE) && (cnt == TW'(TIMEOUT - 1));
    assign fin     = (ph == W_HIGH) && rb_s2;
    assign tmo     = expired && !fin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_s1 <= 1'b1;
            rb_s2 <= 1'b1;
            ph    <= W_IDLE;
            cnt   <= '0;
        end else begin
            rb_s1 <= rb_async;
            rb_s2 <= rb_s1;
            unique case (ph)
                W_IDLE: if (go) begin
                    ph  <= W_LOW;
                    cnt <= '0;
                end
                W_LOW: begin
                    cnt <= cnt + 1'b1;
                    if (expired)     ph <= W_IDLE;
                    else if (!rb_s2) ph <= W_HIGH;
                end
                W_HIGH: begin
                    cnt <= cnt + 1'b1;
                    if (fin || expired) ph <= W_IDLE;
                end
                default: ph <= W_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nand_cb_seq.sv
module nand_cb_seq
    import nand_cb_pkg::*;
#(
    parameter int ROW_W   = 16,
    parameter int COL_W   = 12,
    parameter int T_WL    = 2,
    parameter int T_WH    = 1,
    parameter int T_RL    = 2,
    parameter int TIMEOUT = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ROW_W-1:0] src_row,
    input  logic [ROW_W-1:0] dst_row,
    input  logic             has_patch,
    input  logic             pt_valid,
    input  logic             pt_first,
    input  logic             pt_last,
    input  logic [COL_W-1:0] pt_col,
    input  logic [7:0]       pt_data,
    output logic             pt_ready,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic             timeout,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_io_out,
    output logic             nand_io_oe,
    input  logic [7:0]       nand_io_in,
    input  logic             nand_rb
);
    seq_state_t       state, nxt;
    logic [1:0]       aidx;
    logic [ROW_W-1:0] src_q, dst_q;
    logic             has_q;
    logic             first_q, last_q;
    logic [COL_W-1:0] col_q;
    logic [7:0]       dat_q;
    logic             fail_q, tmo_q;

    logic             bus_go, bus_fin;
    cyc_kind_t        bus_kind;
    logic [7:0]       bus_byte, bus_rbyte;
    logic             w_go, w_fin, w_tmo;
    logic [31:0]      src_addr, dst_addr;
    logic [15:0]      col16;

    assign src_addr = {16'(src_q), 16'h0000};
    assign dst_addr = {16'(dst_q), 16'h0000};
    assign col16    = 16'(col_q);

    nand_cb_bus #(.T_WL(T_WL), .T_WH(T_WH), .T_RL(T_RL)) u_bus (
        .clk(clk), .rst_n(rst_n), .go(bus_go), .kind(bus_kind), .wbyte(bus_byte),
        .fin(bus_fin), .rbyte(bus_rbyte), .cle(nand_cle), .ale(nand_ale),
        .we_n(nand_we_n), .re_n(nand_re_n), .io_out(nand_io_out),
        .io_oe(nand_io_oe), .io_in(nand_io_in)
    );

    nand_cb_rbwait #(.TIMEOUT(TIMEOUT)) u_wait (
        .clk(clk), .rst_n(rst_n), .go(w_go), .rb_async(nand_rb),
        .fin(w_fin), .tmo(w_tmo)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (start) nxt = S_RD_CMD;
            S_RD_CMD:  if (bus_fin) nxt = S_RD_ADDR;
            S_RD_ADDR: if (bus_fin && aidx == 2'd3) nxt = S_RD_CONF;
            S_RD_CONF: if (bus_fin) nxt = S_RD_BUSY;
            S_RD_BUSY: if (w_fin) nxt = S_PG_CMD; else if (w_tmo) nxt = S_FINISH;
            S_PG_CMD:  if (bus_fin) nxt = S_PG_ADDR;
            S_PG_ADDR: if (bus_fin && aidx == 2'd3) nxt = has_q ? S_PT_WAIT : S_PG_CONF;
            S_PT_WAIT: if (pt_valid) nxt = pt_first ? S_PT_CMD : S_PT_DATA;
            S_PT_CMD:  if (bus_fin) nxt = S_PT_COL;
            S_PT_COL:  if (bus_fin && aidx == 2'd1) nxt = S_PT_DATA;
            S_PT_DATA: if (bus_fin) nxt = last_q ? S_PG_CONF : S_PT_WAIT;
            S_PG_CONF: if (bus_fin) nxt = S_PG_BUSY;
            S_PG_BUSY: if (w_fin) nxt = S_ST_CMD; else if (w_tmo) nxt = S_FINISH;
            S_ST_CMD:  if (bus_fin) nxt = S_ST_READ;
            S_ST_READ: if (bus_fin) nxt = S_FINISH;
            S_FINISH:  nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // state register and operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            aidx    <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            has_q   <= 1'b0;
            first_q <= 1'b0;
            last_q  <= 1'b0;
            col_q   <= '0;
            dat_q   <= '0;
            fail_q  <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            state <= nxt;
            if (state != nxt)  aidx <= '0;
            else if (bus_fin)  aidx <= aidx + 1'b1;
            if (state == S_IDLE && start) begin
                src_q  <= src_row;
                dst_q  <= dst_row;
                has_q  <= has_patch;
                fail_q <= 1'b0;
                tmo_q  <= 1'b0;
            end
            if (state == S_PT_WAIT && pt_valid) begin
                first_q <= pt_first;
                last_q  <= pt_last;
                col_q   <= pt_col;
                dat_q   <= pt_data;
            end
            if ((state == S_RD_BUSY || state == S_PG_BUSY) && w_tmo && !w_fin) begin
                tmo_q  <= 1'b1;
                fail_q <= 1'b1;
            end
            if (state == S_ST_READ && bus_fin) fail_q <= bus_rbyte[0];
        end
    end

    // outputs and bus requests
    always_comb begin
        busy      = (state != S_IDLE);
        nand_ce_n = (state == S_IDLE);
        done      = (state == S_FINISH);
        pt_ready  = (state == S_PT_WAIT);
        fail      = fail_q;
        timeout   = tmo_q;
        w_go      = (state == S_RD_BUSY) || (state == S_PG_BUSY);
        bus_go    = 1'b1;
        bus_kind  = CYC_CMD;
        bus_byte  = 8'h00;
        unique case (state)
            S_RD_CMD:  bus_byte = OP_PAGE_READ;
            S_RD_ADDR: begin bus_kind = CYC_ADDR; bus_byte = src_addr[{aidx, 3'b000} +: 8]; end
            S_RD_CONF: bus_byte = OP_CB_READ;
            S_PG_CMD,
            S_PT_CMD:  bus_byte = OP_PROG;
            S_PG_ADDR: begin bus_kind = CYC_ADDR; bus_byte = dst_addr[{aidx, 3'b000} +: 8]; end
            S_PT_COL:  begin bus_kind = CYC_ADDR; bus_byte = col16[{aidx[0], 3'b000} +: 8]; end
            S_PT_DATA: begin bus_kind = CYC_DATA; bus_byte = dat_q; end
            S_PG_CONF: bus_byte = OP_CONFIRM;
            S_ST_CMD:  bus_byte = OP_STATUS;
            S_ST_READ: bus_kind = CYC_READ;
            default:   bus_go = 1'b0;
        endcase
    end

endmodule

// File: rtl/nand_cb_chk.sv
module nand_cb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       fail,
    input logic       timeout,
    input logic       pt_ready,
    input logic       nand_ce_n,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic [7:0] nand_io_out,
    input logic       nand_io_oe
);
    p_latch_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> ($stable(nand_cle) && $stable(nand_ale) && $stable(nand_io_out)));

    p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_io_oe);

    p_ce_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> nand_ce_n);

    p_done_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

    p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_tmo_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timeout) |-> fail);

    p_patch_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pt_ready |-> (nand_we_n && nand_re_n && !nand_ce_n));
endmodule

bind nand_cb_seq nand_cb_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fail(fail),
    .timeout(timeout), .pt_ready(pt_ready), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe)
);

// File: tb/nand_cb_seq_bench.sv
module nand_cb_seq_bench;
    localparam int ROW_W = 16, COL_W = 12;
    localparam int T_WL = 2, T_WH = 1, T_RL = 2, TIMEOUT = 200;
    localparam int BUSY_LEN = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, has_patch = 1'b0;
    logic [ROW_W-1:0] src_row = '0, dst_row = '0;
    logic pt_valid = 1'b0, pt_first = 1'b0, pt_last = 1'b0;
    logic [COL_W-1:0] pt_col = '0;
    logic [7:0] pt_data = '0;
    logic pt_ready, busy, done, fail, timeout;
    logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0] nand_io_out, nand_io_in;
    logic nand_rb = 1'b1;

    always #10 clk = ~clk;

    nand_cb_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .T_WL(T_WL), .T_WH(T_WH),
                  .T_RL(T_RL), .TIMEOUT(TIMEOUT)) u_nand_cb_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .src_row(src_row), .dst_row(dst_row),
        .has_patch(has_patch), .pt_valid(pt_valid), .pt_first(pt_first),
        .pt_last(pt_last), .pt_col(pt_col), .pt_data(pt_data), .pt_ready(pt_ready),
        .busy(busy), .done(done), .fail(fail), .timeout(timeout),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
        .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb(nand_rb)
    );

    int checks = 0, errors = 0;

    // behavioural flash responder
    logic [9:0] log_q [0:63];
    int log_n = 0, width_err = 0, busy_latch = 0, re_pulses = 0, re_width_err = 0;
    int we_low = 0, re_low = 0, rb_delay = 0, rb_hold = 0;
    bit hang = 1'b0, prev_we = 1'b1, prev_re = 1'b1;
    logic [7:0] status_val = 8'h00;

    assign nand_io_in = !nand_re_n ? status_val : 8'h00;

    always @(negedge clk) begin
        if (!nand_we_n) we_low++;
        if (!nand_re_n) re_low++;
        if (nand_we_n && !prev_we) begin
            if (log_n < 64) log_q[log_n] = {nand_cle, nand_ale, nand_io_out};
            log_n++;
            if (we_low != T_WL) width_err++;
            if (!nand_rb) busy_latch++;
            if (nand_cle && (nand_io_out == 8'h35 || nand_io_out == 8'h10)) rb_delay = 2;
            we_low = 0;
        end
        if (nand_re_n && !prev_re) begin
            re_pulses++;
            if (re_low != T_RL) re_width_err++;
            re_low = 0;
        end
        prev_we = nand_we_n;
        prev_re = nand_re_n;
        if (rb_delay > 0) begin
            rb_delay--;
            if (rb_delay == 0) begin nand_rb = 1'b0; rb_hold = BUSY_LEN; end
        end else if (!nand_rb && !hang) begin
            if (rb_hold > 0) rb_hold--;
            else nand_rb = 1'b1;
        end
    end

    // expected sequence and patch list
    logic [9:0] exp_q [0:63];
    int exp_n = 0;
    logic [COL_W-1:0] p_col [0:7];
    logic [7:0] p_dat [0:7];
    bit p_first [0:7];
    bit p_last [0:7];
    int p_n = 0;
    bit got_fail, got_tmo;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic ex(input logic [1:0] k, input logic [7:0] b);
        exp_q[exp_n] = {k, b};
        exp_n++;
    endtask

    task automatic ex_addr(input logic [15:0] row);
        ex(2'b01, 8'h00); ex(2'b01, 8'h00); ex(2'b01, row[7:0]); ex(2'b01, row[15:8]);
    endtask

    task automatic clear_log();
        log_n = 0; exp_n = 0; width_err = 0; busy_latch = 0;
        re_pulses = 0; re_width_err = 0;
    endtask

    task automatic run_op(input logic [15:0] src, input logic [15:0] dst,
                          input bit patches, input bit restart);
        int pi = 0;
        bit seen = 1'b0;
        @(negedge clk);
        src_row = src; dst_row = dst; has_patch = patches; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 3000 && !seen; c++) begin
            if (restart && c == 30) begin
                src_row = 16'h5555; dst_row = 16'h6666; start = 1'b1;
            end else start = 1'b0;
            if (pt_ready && !pt_valid && pi < p_n) begin
                pt_valid = 1'b1; pt_col = p_col[pi]; pt_data = p_dat[pi];
                pt_first = p_first[pi]; pt_last = p_last[pi]; pi++;
            end else pt_valid = 1'b0;
            if (done) begin seen = 1'b1; got_fail = fail; got_tmo = timeout; end
            else @(negedge clk);
        end
        start = 1'b0; pt_valid = 1'b0;
        chk(seen, "R9", "done seen", seen, 1);
    endtask

    task automatic cmp_log(input string req);
        chk(log_n == exp_n, req, "cycle count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++)
            chk(log_q[i] == exp_q[i], req, $sformatf("cycle %0d", i), log_q[i], exp_q[i]);
    endtask

    task automatic t_reset();
        chk(nand_ce_n && nand_we_n && nand_re_n, "R11", "strobes idle", {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
        chk(!nand_cle && !nand_ale && !nand_io_oe, "R11", "latch lines", {nand_cle, nand_ale, nand_io_oe}, 0);
        chk(!busy && !done && !pt_ready, "R11", "handshake", {busy, done, pt_ready}, 0);
    endtask

    task automatic t_plain();
        clear_log(); p_n = 0; status_val = 8'hE0;
        ex(2'b10, 8'h00); ex_addr(16'h1234); ex(2'b10, 8'h35);
        ex(2'b10, 8'h85); ex_addr(16'hABCD);
        ex(2'b10, 8'h10); ex(2'b10, 8'h70);
        run_op(16'h1234, 16'hABCD, 1'b0, 1'b1);
        cmp_log("R1 R3 R5 R10");
        chk(busy_latch == 0, "R2", "latched while busy", busy_latch, 0);
        chk(width_err == 0, "R7", "we low width errors", width_err, 0);
        chk(re_pulses == 1, "R6", "status reads", re_pulses, 1);
        chk(re_width_err == 0, "R6", "re low width errors", re_width_err, 0);
        chk(!got_fail && !got_tmo, "R6", "pass flags", {got_fail, got_tmo}, 0);
        @(negedge clk);
        chk(!busy && nand_ce_n, "R9", "idle after done", {busy, nand_ce_n}, 2'b01);
        chk(!fail, "R9", "fail held", fail, 0);
    endtask

    task automatic t_patch();
        clear_log(); status_val = 8'h01;
        p_col[0] = 12'h123; p_dat[0] = 8'h11; p_first[0] = 1; p_last[0] = 0;
        p_col[1] = 12'h000; p_dat[1] = 8'h22; p_first[1] = 0; p_last[1] = 0;
        p_col[2] = 12'h7FF; p_dat[2] = 8'h33; p_first[2] = 1; p_last[2] = 1;
        p_n = 3;
        ex(2'b10, 8'h00); ex_addr(16'h0042); ex(2'b10, 8'h35);
        ex(2'b10, 8'h85); ex_addr(16'h0100);
        ex(2'b10, 8'h85); ex(2'b01, 8'h23); ex(2'b01, 8'h01); ex(2'b00, 8'h11);
        ex(2'b00, 8'h22);
        ex(2'b10, 8'h85); ex(2'b01, 8'hFF); ex(2'b01, 8'h07); ex(2'b00, 8'h33);
        ex(2'b10, 8'h10); ex(2'b10, 8'h70);
        run_op(16'h0042, 16'h0100, 1'b1, 1'b0);
        cmp_log("R4");
        chk(busy_latch == 0, "R2", "latched while busy", busy_latch, 0);
        chk(width_err == 0, "R7", "we low width errors", width_err, 0);
        chk(got_fail && !got_tmo, "R6", "status bit0 fail", {got_fail, got_tmo}, 2'b10);
    endtask

    task automatic t_timeout();
        int n_at_done;
        clear_log(); p_n = 0; status_val = 8'h00; hang = 1'b1;
        ex(2'b10, 8'h00); ex_addr(16'h0777); ex(2'b10, 8'h35);
        run_op(16'h0777, 16'h0888, 1'b0, 1'b0);
        chk(got_fail && got_tmo, "R8", "abort flags", {got_fail, got_tmo}, 2'b11);
        n_at_done = log_n;
        repeat (20) @(negedge clk);
        chk(log_n == n_at_done, "R8", "no cycles after abort", log_n, n_at_done);
        chk(nand_ce_n && !busy, "R8", "ce released", {nand_ce_n, busy}, 2'b10);
        chk(timeout && fail, "R9", "flags held", {timeout, fail}, 2'b11);
        cmp_log("R8");
        hang = 1'b0;
        repeat (30) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_plain();
        t_patch();
        t_timeout();
        t_plain();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule